// File: doc/BRIEF.md
# Processor idle and wake controller

This block sits next to a small core's fetch unit and handles two low-power wait instructions. When either wait instruction retires, the block raises a hold that stops fetch and execution. It then watches the interrupt lines and decides when the core wakes. It also decides whether the wake enters the interrupt trap or falls through to the instruction after the wait.

In the general wait mode, any interrupt that is pending and enabled in the per-line mask wakes the core. In the external-only wait mode, a line wakes the core only if it is also marked external. Internal sources stay pending and have no effect. If the global disable bit is set at the moment of the wake, the core resumes in line and the interrupt is left pending. If the bit is clear, the lowest-numbered waking line is trapped to and acknowledged. The block only reads the global disable bit and never drives it.

Top module: `idle_wake_ctrl`

## Requirements
- R1: After a wait strobe in the running state, `fetch_hold_o` is high from the next clock edge until the edge at which a wake condition is seen.
- R2: In the general wait mode (entered with `idle_gen_i`), a line whose bit is set in both `irq_pend_i` and `irq_en_i` is a wake condition, whether or not it is external.
- R3: At a wake with `gint_dis_i` = 1, `resume_o` pulses for one cycle, `trap_o` stays low and `irq_ack_o` stays all zero.
- R4: At a wake with `gint_dis_i` = 0, `trap_o` pulses for one cycle and `resume_o` stays low.
- R5: In the external-only wait mode (entered with `idle_ext_i`), only lines set in `irq_pend_i`, `irq_en_i` and `irq_ext_i` wake the core. Pending enabled internal lines leave `fetch_hold_o` high.
- R6: `trap_vec_o` holds the lowest index among the waking lines during the `trap_o` pulse.
- R7: `irq_ack_o` is one-hot during a `trap_o` pulse, with the bit at `trap_vec_o` set. At all other times it is zero.
- R8: `fetch_hold_o` falls on the same edge that raises exactly one of `trap_o` or `resume_o`. Neither pulse appears without that fall.
- R9: If a waking line is already pending when the strobe arrives, the hold lasts exactly one cycle.
- R10: A synchronous active-high `rst` clears `fetch_hold_o`, `trap_o`, `resume_o`, `trap_vec_o` and `irq_ack_o` to zero.
- R11: Wait strobes that arrive while `fetch_hold_o` is high are ignored; the mode entered first stays in force.
- R12: If both strobes arrive together, the external-only mode is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idle_gen_i | input | 1 | Strobe from the general wait instruction |
| idle_ext_i | input | 1 | Strobe from the external-only wait instruction |
| gint_dis_i | input | 1 | Global interrupt disable, 1 = disabled |
| irq_en_i | input | NIRQ | Per-line interrupt enable mask |
| irq_pend_i | input | NIRQ | Pending interrupt flags |
| irq_ext_i | input | NIRQ | 1 marks a line as an external source |
| fetch_hold_o | output | 1 | Holds fetch and execution while waiting |
| trap_o | output | 1 | One-cycle request to enter the interrupt trap |
| trap_vec_o | output | VW | Index of the trapped line |
| resume_o | output | 1 | One-cycle request to continue at the next instruction |
| irq_ack_o | output | NIRQ | One-hot clear pulse for the serviced pending flag |

## Verification
The bench aims at waits that begin with a waking line already pending. A design that checks for the wake only after a delay would hold for longer than one cycle, and one that wakes combinationally would hold for no cycles at all. Internal-only pending lines in the external-only mode would wake a design that ignores the external marking. Several waking lines at once would expose a priority encoder that picks the highest index. Wakes with the global disable set would expose a design that still pulses trap or acknowledges the flag. Strobes sent during a wait, and both strobes together, would show a design that switches modes or chooses the wrong mode.

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl #(
  parameter int NIRQ = 8,
  localparam int VW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            idle_gen_i,
  input  logic            idle_ext_i,
  input  logic            gint_dis_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic [NIRQ-1:0] irq_pend_i,
  input  logic [NIRQ-1:0] irq_ext_i,
  output logic            fetch_hold_o,
  output logic            trap_o,
  output logic [VW-1:0]   trap_vec_o,
  output logic            resume_o,
  output logic [NIRQ-1:0] irq_ack_o
);
  logic            waiting, ext_only;
  logic [NIRQ-1:0] cand;
  logic [VW-1:0]   pick;
  logic            wake;

  assign cand = irq_pend_i & irq_en_i & (ext_only ? irq_ext_i : {NIRQ{1'b1}});
  assign wake = waiting && (|cand);
  assign fetch_hold_o = waiting;

  always_comb begin
    pick = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (cand[i]) pick = VW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting    <= 1'b0;
      ext_only   <= 1'b0;
      trap_o     <= 1'b0;
      resume_o   <= 1'b0;
      trap_vec_o <= '0;
      irq_ack_o  <= '0;
    end else begin
      trap_o     <= 1'b0;
      resume_o   <= 1'b0;
      trap_vec_o <= '0;
      irq_ack_o  <= '0;
      if (!waiting) begin
        if (idle_gen_i || idle_ext_i) begin
          waiting  <= 1'b1;
          ext_only <= idle_ext_i;
        end
      end else if (wake) begin
        waiting <= 1'b0;
        if (gint_dis_i) begin
          resume_o <= 1'b1;
        end else begin
          trap_o     <= 1'b1;
          trap_vec_o <= pick;
          irq_ack_o  <= NIRQ'(1) << pick;
        end
      end
    end
  end
endmodule

// File: rtl/idle_wake_ctrl_chk.sv
module idle_wake_ctrl_chk #(
  parameter int NIRQ = 8,
  localparam int VW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            idle_gen_i,
  input logic            idle_ext_i,
  input logic            gint_dis_i,
  input logic [NIRQ-1:0] irq_en_i,
  input logic [NIRQ-1:0] irq_pend_i,
  input logic [NIRQ-1:0] irq_ext_i,
  input logic            fetch_hold_o,
  input logic            trap_o,
  input logic [VW-1:0]   trap_vec_o,
  input logic            resume_o,
  input logic [NIRQ-1:0] irq_ack_o,
  input logic            ext_only
);
  assert_hold_enter_R1: assert property (@(posedge clk) disable iff (rst)
    (!fetch_hold_o && (idle_gen_i || idle_ext_i)) |=> fetch_hold_o);
  assert_resume_no_ack_R3: assert property (@(posedge clk) disable iff (rst)
    resume_o |-> (irq_ack_o == '0) && $past(gint_dis_i));
  assert_trap_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> !$past(gint_dis_i));
  assert_ext_only_R5: assert property (@(posedge clk) disable iff (rst)
    (fetch_hold_o && ext_only && ((irq_pend_i & irq_en_i & irq_ext_i) == '0)) |=> fetch_hold_o);
  assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> $onehot(irq_ack_o) && irq_ack_o[trap_vec_o]);
  assert_ack_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !trap_o |-> (irq_ack_o == '0));
  assert_one_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    !(trap_o && resume_o));
  assert_pulse_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    (trap_o || resume_o) |-> $fell(fetch_hold_o));
  assert_fall_gives_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(fetch_hold_o) |-> (trap_o || resume_o));
endmodule

bind idle_wake_ctrl idle_wake_ctrl_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst(rst), .idle_gen_i(idle_gen_i), .idle_ext_i(idle_ext_i),
  .gint_dis_i(gint_dis_i), .irq_en_i(irq_en_i), .irq_pend_i(irq_pend_i),
  .irq_ext_i(irq_ext_i), .fetch_hold_o(fetch_hold_o), .trap_o(trap_o),
  .trap_vec_o(trap_vec_o), .resume_o(resume_o), .irq_ack_o(irq_ack_o),
  .ext_only(ext_only)
);

// File: tb/tb_idle_wake_ctrl.sv
module tb_idle_wake_ctrl;
  localparam int NIRQ = 8;
  localparam int VW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idle_gen_i = 0, idle_ext_i = 0, gint_dis_i = 0;
  logic [NIRQ-1:0] irq_en_i = '0, irq_pend_i = '0, irq_ext_i = '0;
  logic fetch_hold_o, trap_o, resume_o;
  logic [VW-1:0] trap_vec_o;
  logic [NIRQ-1:0] irq_ack_o;

  int n_chk = 0, n_fail = 0;
  string tag = "";

  always #10 clk = ~clk;

  idle_wake_ctrl #(.NIRQ(NIRQ)) dut (.*);

  // reference model, built from the requirements
  logic m_wait = 0, m_ext = 0, e_trap = 0, e_res = 0;
  logic [VW-1:0] e_vec = '0;
  logic [NIRQ-1:0] e_ack = '0;

  function automatic logic [NIRQ-1:0] waking(logic extm, logic [NIRQ-1:0] p, e, x);
    return extm ? (p & e & x) : (p & e);
  endfunction

  function automatic int lowest(logic [NIRQ-1:0] v);
    for (int i = 0; i < NIRQ; i++) if (v[i]) return i;
    return 0;
  endfunction

  always @(posedge clk) begin
    logic [NIRQ-1:0] w;
    w = waking(m_ext, irq_pend_i, irq_en_i, irq_ext_i);
    e_trap <= 0; e_res <= 0; e_vec <= '0; e_ack <= '0;
    if (rst) begin
      m_wait <= 0; m_ext <= 0;
    end else if (!m_wait) begin
      if (idle_gen_i || idle_ext_i) begin m_wait <= 1; m_ext <= idle_ext_i; end
    end else if (w != '0) begin
      m_wait <= 0;
      if (gint_dis_i) e_res <= 1;
      else begin
        e_trap <= 1;
        e_vec <= VW'(lowest(w));
        e_ack <= NIRQ'(1) << lowest(w);
      end
    end
  end

  task automatic chk(string t, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", t, got, exp, $time);
    end
  endtask

  task automatic check_all();
    string th;
    th = (tag != "") ? tag : (m_ext ? "R5" : "R1");
    chk(th, fetch_hold_o, m_wait);
    chk(e_res ? "R3" : "R4", trap_o, e_trap);
    chk(e_trap ? "R4" : "R3", resume_o, e_res);
    chk("R6", trap_vec_o, e_vec);
    chk("R7", irq_ack_o, e_ack);
    if (trap_o || resume_o) chk("R8", fetch_hold_o, 0);
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_all();
    end
  endtask

  task automatic strobe(logic g, logic x);
    idle_gen_i = g; idle_ext_i = x;
    step(1);
    idle_gen_i = 0; idle_ext_i = 0;
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    step(3);
    tag = "R10"; check_all();
    rst = 0;
    irq_en_i = 8'hFF; irq_ext_i = 8'hF0;

    // R9: waking line already pending at the strobe
    tag = "R9"; irq_pend_i = 8'h20; gint_dis_i = 0;
    strobe(1, 0); chk("R9", fetch_hold_o, 1);
    step(1); chk("R9", trap_o, 1); chk("R6", trap_vec_o, 5);
    irq_pend_i = 0; step(2);

    // R2: internal line wakes the general mode; R3 resume with disable set
    tag = "R2"; gint_dis_i = 1;
    strobe(1, 0); step(3); chk("R2", fetch_hold_o, 1);
    irq_pend_i = 8'h01; step(1); chk("R3", resume_o, 1); chk("R3", irq_ack_o, 0);
    irq_pend_i = 0; step(2);

    // R5: internal lines ignored in external-only mode; R6 priority
    tag = "R5"; gint_dis_i = 0;
    strobe(0, 1); irq_pend_i = 8'h0F; step(4); chk("R5", fetch_hold_o, 1);
    irq_pend_i = 8'hCF; step(1); chk("R6", trap_vec_o, 6); chk("R7", irq_ack_o, 8'h40);
    irq_pend_i = 0; step(2);

    // R11: later strobes ignored while waiting
    tag = "R11";
    strobe(0, 1); strobe(1, 0); strobe(1, 1);
    irq_pend_i = 8'h02; step(3); chk("R11", fetch_hold_o, 1);
    irq_pend_i = 8'h80; step(1); chk("R11", trap_o, 1);
    irq_pend_i = 0; step(2);

    // R12: simultaneous strobes pick external-only
    tag = "R12";
    strobe(1, 1); irq_pend_i = 8'h04; step(3); chk("R12", fetch_hold_o, 1);
    irq_pend_i = 8'h10; step(2); irq_pend_i = 0; step(2);

    // R10: reset during a wait
    strobe(1, 0); rst = 1; tag = "R10"; step(2); chk("R10", fetch_hold_o, 0);
    rst = 0; tag = ""; step(1);

    // random mix
    for (int c = 0; c < 4000; c++) begin
      idle_gen_i = ($urandom % 8) == 0;
      idle_ext_i = ($urandom % 8) == 0;
      gint_dis_i = $urandom % 2;
      irq_en_i   = NIRQ'($urandom);
      irq_ext_i  = NIRQ'($urandom);
      irq_pend_i = (($urandom % 4) == 0) ? NIRQ'($urandom) : '0;
      step(1);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule